// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block is one channel of a scatter-gather DMA engine. Software programs the address of a descriptor chain, as a low and a high 32-bit word, and then writes the enable command. The walker reads each 8-byte descriptor from memory as two 32-bit words. It checks the descriptor's flags and length. For each transfer descriptor it hands the buffer address and byte length to a separate data mover, and it waits for that mover to report completion before it fetches the next descriptor, which lies 8 bytes further on.

The walk ends normally when a descriptor marked as the last one has completed. At that point the walker pulses `done` for one cycle. A malformed descriptor ends the walk with a sticky error flag and no done pulse. A malformed descriptor is one whose valid flag is clear or whose length is not a whole number of 32-bit words. Writing the enable command with bit 0 cleared abandons a walk at any point. Moving the data itself is the job of the data mover.

Top module: `sg_list_walker`

## Requirements
- R1: After reset `busy`, `done`, `err`, `mem_req` and `xfer_start` are all low.
- R2: Configuration selects: `cfg_sel`=0 writes the low word of the list address, 1 writes the high word, and 2 is the enable command. The first fetch address is {high, low}. A descriptor at address P is read as header word P and buffer word P+4, and the next descriptor starts at P+8.
- R3: The header word is little-endian. Bits [7:0] are the flag byte, with bit 0 valid, bit 1 last and bit 5 transfer. Bits [15:8] are reserved and ignored. Bits [31:16] are the byte length. For a transfer descriptor, `xfer_start` pulses for exactly one cycle with `xfer_addr` equal to the buffer word and `xfer_len` equal to the length.
- R4: Only one transfer is outstanding at a time. The next descriptor is not fetched until `xfer_done` has been seen for the current one.
- R5: A valid descriptor with the transfer flag clear issues no transfer. The walk still continues to the next descriptor, or finishes if the last flag is set.
- R6: After the last descriptor completes, `done` is high for exactly one cycle, and `busy` is already low in that cycle.
- R7: A descriptor with the valid flag clear ends the walk. It sets `err`, issues no transfer, gives no `done`, and drops `busy`.
- R8: A descriptor whose length is not a multiple of 4 ends the walk in the same way as R7.
- R9: `err` stays set until the next enable command starts a new walk, and that start clears it.
- R10: Writes to the list address words while `busy` is high are ignored.
- R11: An enable write with bit 0 clear while busy stops the walk. `busy` falls on the next cycle, no `done` or `err` follows, and a late `xfer_done` is ignored.
- R12: An enable write with bit 0 set while busy is ignored, and the running walk is unaffected.
- R13: `mem_req` and `mem_addr` are held until `mem_ack` accepts the read. Read data is taken in the cycle of `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target (0 low address, 1 high address, 2 enable) |
| cfg_wdata | input | 32 | Configuration write data |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | PTR_W (64) | Byte address of the requested word |
| mem_ack | input | 1 | Read accepted, data valid this cycle |
| mem_rdata | input | 32 | Read data word |
| xfer_start | output | 1 | One-cycle transfer request |
| xfer_addr | output | BUF_AW (32) | Transfer buffer address |
| xfer_len | output | LEN_W (16) | Transfer length in bytes |
| xfer_done | input | 1 | Data mover finished the current transfer |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when the chain has completed |
| err | output | 1 | Sticky malformed-descriptor flag |

## Verification
The embedded assertions watch the cycle-level rules on every clock. These are the rules they cover:
- the read request and its address stay steady until accepted;
- the transfer request is a single-cycle pulse;
- the done pulse never coincides with `busy`;
- an error never rises together with done;
- the list address registers do not move under a write while busy;
- an idle channel never requests anything.

Other behaviour depends on descriptor contents in memory and can only be shown by the bench's scenarios. This covers the fetch address sequence across a chain, the ordering of a fetch after the previous `xfer_done`, and the skipping of non-transfer descriptors. It also covers the rejection of invalid or misaligned descriptors, the clearing of the sticky error on restart, and the abort that swallows a late completion.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  localparam int DESC_BYTES = 8;
  localparam int WORD_BYTES = 4;
  localparam int FLAG_VALID = 0;
  localparam int FLAG_LAST  = 1;
  localparam int FLAG_XFER  = 5;
  localparam int LEN_LSB    = 16;
  localparam int HDR_LEN_W  = 16;

  typedef enum logic [1:0] {
    SEL_BASE_LO = 2'd0,
    SEL_BASE_HI = 2'd1,
    SEL_ENABLE  = 2'd2
  } cfg_sel_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_HDR,
    W_BUF,
    W_CHECK,
    W_ISSUE,
    W_WAIT
  } walk_state_e;

  function automatic logic hdr_valid(input logic [31:0] w);
    return w[FLAG_VALID];
  endfunction

  function automatic logic hdr_last(input logic [31:0] w);
    return w[FLAG_LAST];
  endfunction

  function automatic logic hdr_is_xfer(input logic [31:0] w);
    return w[FLAG_XFER];
  endfunction

  function automatic logic [HDR_LEN_W-1:0] hdr_len(input logic [31:0] w);
    return w[LEN_LSB +: HDR_LEN_W];
  endfunction

  function automatic logic len_word_aligned(input logic [HDR_LEN_W-1:0] len);
    return (len[1:0] == 2'b00);
  endfunction

endpackage

// File: rtl/sgw_cfg_regs.sv
module sgw_cfg_regs
  import sgw_pkg::*;
#(
  parameter int PTR_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             busy_i,
  output logic [PTR_W-1:0] list_base,
  output logic             start_evt,
  output logic             stop_evt
);

  logic [31:0] base_lo_q;
  logic [31:0] base_hi_q;
  logic        addr_wr_ok;
  logic        en_wr;

  assign addr_wr_ok = cfg_we && !busy_i;
  assign en_wr      = cfg_we && (cfg_sel == SEL_ENABLE);
  assign start_evt  = en_wr && cfg_wdata[0] && !busy_i;
  assign stop_evt   = en_wr && !cfg_wdata[0] && busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
    end else if (addr_wr_ok) begin
      if (cfg_sel == SEL_BASE_LO) base_lo_q <= cfg_wdata;
      if (cfg_sel == SEL_BASE_HI) base_hi_q <= cfg_wdata;
    end
  end

  generate
    if (PTR_W > 32) begin : g_wide
      assign list_base = {base_hi_q[PTR_W-33:0], base_lo_q};
      logic unused_hi;
      assign unused_hi = 1'b0;
    end else begin : g_narrow
      assign list_base = base_lo_q[PTR_W-1:0];
      logic unused_hi;
      assign unused_hi = ^base_hi_q;
    end
  endgenerate

  AST_BASE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && cfg_we && (cfg_sel != SEL_ENABLE)) |=> ($stable(base_lo_q) && $stable(base_hi_q))) // R10
    else $error("base address changed while busy");

endmodule

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
  import sgw_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [31:0]      hdr,
  output logic             d_last,
  output logic             d_xfer,
  output logic [LEN_W-1:0] d_len,
  output logic             d_ok
);

  logic [HDR_LEN_W-1:0] full_len;
  logic unused_rsv;

  assign full_len   = hdr_len(hdr);
  assign d_last     = hdr_last(hdr);
  assign d_xfer     = hdr_is_xfer(hdr);
  assign d_len      = full_len[LEN_W-1:0];
  assign d_ok       = hdr_valid(hdr) && len_word_aligned(full_len);
  assign unused_rsv = ^{hdr[15:6], hdr[4:2]};

endmodule

// File: rtl/sgw_walk_fsm.sv
module sgw_walk_fsm
  import sgw_pkg::*;
#(
  parameter int PTR_W  = 64,
  parameter int BUF_AW = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [PTR_W-1:0]  list_base,
  output logic              mem_req,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [31:0]       hdr_q,
  input  logic              d_last,
  input  logic              d_xfer,
  input  logic              d_ok,
  output logic              xfer_start,
  output logic [BUF_AW-1:0] xfer_addr,
  input  logic              xfer_done,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam logic [PTR_W-1:0] STEP_DESC = PTR_W'(DESC_BYTES);
  localparam logic [PTR_W-1:0] STEP_WORD = PTR_W'(WORD_BYTES);

  walk_state_e       state_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [BUF_AW-1:0] buf_q;
  logic              done_q;
  logic              err_q;

  logic desc_complete;
  logic finish_evt;
  logic advance_evt;
  logic fault_evt;
  logic unused_buf;

  assign desc_complete = !stop_evt &&
    (((state_q == W_CHECK) && d_ok && !d_xfer) ||
     ((state_q == W_WAIT) && xfer_done));
  assign finish_evt  = desc_complete && d_last;
  assign advance_evt = desc_complete && !d_last;
  assign fault_evt   = !stop_evt && (state_q == W_CHECK) && !d_ok;
  assign unused_buf  = ^mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      ptr_q   <= '0;
      buf_q   <= '0;
      hdr_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= finish_evt;
      if (fault_evt) err_q <= 1'b1;
      if (start_evt) err_q <= 1'b0;
      if (advance_evt) ptr_q <= ptr_q + STEP_DESC;
      if (stop_evt) begin
        state_q <= W_IDLE;
      end else begin
        case (state_q)
          W_IDLE: if (start_evt) begin
            ptr_q   <= list_base;
            state_q <= W_HDR;
          end
          W_HDR: if (mem_ack) begin
            hdr_q   <= mem_rdata;
            state_q <= W_BUF;
          end
          W_BUF: if (mem_ack) begin
            buf_q   <= mem_rdata[BUF_AW-1:0];
            state_q <= W_CHECK;
          end
          W_CHECK: begin
            if (fault_evt || finish_evt) state_q <= W_IDLE;
            else if (advance_evt)        state_q <= W_HDR;
            else                         state_q <= W_ISSUE;
          end
          W_ISSUE: state_q <= W_WAIT;
          W_WAIT: begin
            if (finish_evt)       state_q <= W_IDLE;
            else if (advance_evt) state_q <= W_HDR;
          end
          default: state_q <= W_IDLE;
        endcase
      end
    end
  end

  assign mem_req    = (state_q == W_HDR) || (state_q == W_BUF);
  assign mem_addr   = (state_q == W_BUF) ? (ptr_q + STEP_WORD) : ptr_q;
  assign xfer_start = (state_q == W_ISSUE);
  assign xfer_addr  = buf_q;
  assign busy       = (state_q != W_IDLE);
  assign done       = done_q;
  assign err        = err_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !stop_evt) |=> (mem_req && $stable(mem_addr))) // R13
    else $error("read request dropped before acceptance");

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start) // R3
    else $error("transfer request longer than one cycle");

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) // R6
    else $error("done while still busy");

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) // R6
    else $error("done longer than one cycle");

  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!done && !busy)) // R7
    else $error("error raised alongside done or busy");

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !xfer_start)) // R1
    else $error("idle channel requesting");

endmodule

// File: rtl/sg_list_walker.sv
module sg_list_walker
  import sgw_pkg::*;
#(
  parameter int PTR_W  = 64,
  parameter int BUF_AW = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              mem_req,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_start,
  output logic [BUF_AW-1:0] xfer_addr,
  output logic [LEN_W-1:0]  xfer_len,
  input  logic              xfer_done,
  output logic              busy,
  output logic              done,
  output logic              err
);

  logic [PTR_W-1:0] list_base;
  logic             start_evt;
  logic             stop_evt;
  logic [31:0]      hdr_q;
  logic             d_last;
  logic             d_xfer;
  logic             d_ok;

  sgw_cfg_regs #(.PTR_W(PTR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .busy_i    (busy),
    .list_base (list_base),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  sgw_desc_decode #(.LEN_W(LEN_W)) u_dec (
    .hdr    (hdr_q),
    .d_last (d_last),
    .d_xfer (d_xfer),
    .d_len  (xfer_len),
    .d_ok   (d_ok)
  );

  sgw_walk_fsm #(.PTR_W(PTR_W), .BUF_AW(BUF_AW), .LEN_W(LEN_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .list_base  (list_base),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .hdr_q      (hdr_q),
    .d_last     (d_last),
    .d_xfer     (d_xfer),
    .d_ok       (d_ok),
    .xfer_start (xfer_start),
    .xfer_addr  (xfer_addr),
    .xfer_done  (xfer_done),
    .busy       (busy),
    .done       (done),
    .err        (err)
  );

endmodule

// File: tb/sg_list_walker_tb.sv
`timescale 1ns/1ps
module sg_list_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        xfer_start;
  logic [31:0] xfer_addr;
  logic [15:0] xfer_len;
  logic        xfer_done = 1'b0;
  logic        busy, done, err;

  always #2 clk = ~clk;

  sg_list_walker dut_i (.*);

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [31:0] mem [0:63];
  logic [63:0] fetch_log [0:15];
  int          fetch_cyc [0:15];
  logic [31:0] xa_log [0:7];
  logic [15:0] xl_log [0:7];
  int          xdone_cyc [0:7];
  int n_fetch = 0, n_xfer = 0, n_xdone = 0, n_done = 0, done_busy_bad = 0;
  int pend = 0;

  // Each entry: {exp_xfer, exp_done, exp_err, flags, reserved, len, buf_addr}
  localparam logic [66:0] VEC [0:4] = '{
    {3'b110, 8'h23, 8'h00, 16'h0100, 32'h1000_0000},
    {3'b001, 8'h22, 8'h00, 16'h0010, 32'h2000_0000},
    {3'b001, 8'h23, 8'h00, 16'h0102, 32'h3000_0000},
    {3'b010, 8'h03, 8'h00, 16'h0040, 32'h4000_0000},
    {3'b110, 8'h23, 8'hA5, 16'hFFFC, 32'hDEAD_BEEC}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory, data mover and event monitor, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (done) begin
        n_done++;
        if (busy) done_busy_bad++;
      end
      xfer_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          xfer_done = 1'b1;
          if (n_xdone < 8) xdone_cyc[n_xdone] = cyc;
          n_xdone++;
        end
      end
      if (xfer_start) begin
        if (n_xfer < 8) begin
          xa_log[n_xfer] = xfer_addr;
          xl_log[n_xfer] = xfer_len;
        end
        n_xfer++;
        pend = 3;
      end
      if (mem_req && !mem_ack) begin
        mem_ack = 1'b1;
        mem_rdata = mem[mem_addr[7:2]];
        if (n_fetch < 16) begin
          fetch_log[n_fetch] = mem_addr;
          fetch_cyc[n_fetch] = cyc;
        end
        n_fetch++;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  initial begin
    wait (cyc > 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_logs();
    n_fetch = 0; n_xfer = 0; n_xdone = 0; n_done = 0; done_busy_bad = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {63'd0, busy}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 err", {63'd0, err}, 64'd0);
    chk("R1 mem_req", {63'd0, mem_req}, 64'd0);
    chk("R1 xfer_start", {63'd0, xfer_start}, 64'd0);

    // table of single-descriptor cases at 0x40
    for (int v = 0; v < 5; v++) begin
      mem[16] = {VEC[v][47:32], VEC[v][55:48], VEC[v][63:56]};
      mem[17] = VEC[v][31:0];
      cfg_write(2'd0, 32'h40);
      cfg_write(2'd1, 32'h0);
      clear_logs();
      cfg_write(2'd2, 32'h1);
      wait_idle();
      chk($sformatf("R3 R5 vec%0d xfer count", v), 64'(n_xfer), {63'd0, VEC[v][66]});
      if (VEC[v][66]) begin
        chk($sformatf("R3 vec%0d xfer_addr", v), {32'd0, xa_log[0]}, {32'd0, VEC[v][31:0]});
        chk($sformatf("R3 vec%0d xfer_len", v), {48'd0, xl_log[0]}, {48'd0, VEC[v][47:32]});
      end
      chk($sformatf("R6 vec%0d done count", v), 64'(n_done), {63'd0, VEC[v][65]});
      chk($sformatf("R7 R8 R9 vec%0d err", v), {63'd0, err}, {63'd0, VEC[v][64]});
      chk($sformatf("R6 vec%0d done with busy", v), 64'(done_busy_bad), 64'd0);
      if (v == 2) begin
        repeat (5) @(negedge clk);
        chk("R9 err sticky", {63'd0, err}, 64'd1);
        cfg_write(2'd2, 32'h1);
        chk("R9 err cleared on start", {63'd0, err}, 64'd0);
        wait_idle();
      end
    end

    // chain of three at {1, 0x80}: transfer, skip, last transfer
    mem[32] = {16'h0008, 8'h00, 8'h21};
    mem[33] = 32'hA000_0000;
    mem[34] = {16'h0000, 8'h00, 8'h01};
    mem[35] = 32'hB000_0000;
    mem[36] = {16'h0004, 8'h00, 8'h23};
    mem[37] = 32'hC000_0000;
    cfg_write(2'd0, 32'h80);
    cfg_write(2'd1, 32'h1);
    clear_logs();
    cfg_write(2'd2, 32'h1);
    cfg_write(2'd0, 32'h40);
    cfg_write(2'd1, 32'h0);
    cfg_write(2'd2, 32'h1);
    wait_idle();
    chk("R2 fetch count", 64'(n_fetch), 64'd6);
    chk("R2 fetch0", fetch_log[0], 64'h1_0000_0080);
    chk("R2 fetch1", fetch_log[1], 64'h1_0000_0084);
    chk("R2 fetch2", fetch_log[2], 64'h1_0000_0088);
    chk("R2 fetch5", fetch_log[5], 64'h1_0000_0094);
    chk("R5 chain xfers", 64'(n_xfer), 64'd2);
    chk("R3 chain xfer0 addr", {32'd0, xa_log[0]}, 64'hA000_0000);
    chk("R5 chain xfer1 addr", {32'd0, xa_log[1]}, 64'hC000_0000);
    chk("R4 fetch after xfer_done", 64'(fetch_cyc[2] > xdone_cyc[0]), 64'd1);
    chk("R12 chain done count", 64'(n_done), 64'd1);
    chk("R12 chain err", {63'd0, err}, 64'd0);

    // restart without rewriting the base: writes during busy were dropped
    clear_logs();
    cfg_write(2'd2, 32'h1);
    wait_idle();
    chk("R10 base kept", fetch_log[0], 64'h1_0000_0080);
    chk("R10 rerun done", 64'(n_done), 64'd1);

    // abort during an outstanding transfer
    mem[16] = {16'h0020, 8'h00, 8'h23};
    mem[17] = 32'h5000_0000;
    cfg_write(2'd0, 32'h40);
    cfg_write(2'd1, 32'h0);
    clear_logs();
    cfg_write(2'd2, 32'h1);
    for (int i = 0; i < 100; i++) begin
      if (n_xfer != 0) break;
      @(negedge clk);
    end
    cfg_write(2'd2, 32'h0);
    chk("R11 busy after stop", {63'd0, busy}, 64'd0);
    repeat (10) @(negedge clk);
    chk("R11 late xfer_done ignored done", 64'(n_done), 64'd0);
    chk("R11 no err", {63'd0, err}, 64'd0);
    chk("R11 still idle", {63'd0, busy}, 64'd0);
    chk("R13 fetches before stop", 64'(n_fetch), 64'd2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule